// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a 32-bit load/store processor in which one memory serves both instructions and data, and one ALU serves every arithmetic need. Each instruction is executed as a chain of one-cycle steps. A state register walks through those steps. Every step produces the selects and write enables that the surrounding datapath needs for that cycle.

The shared ALU is used three times per instruction. In the first step it increments the program counter. In the second step it computes a speculative branch target while the register file is read. In a later step it performs the instruction's own operation. After the second step the path splits according to the opcode. A branch finishes in one further step, and in that step the program counter is written only when the ALU reports equal operands. A second-level decoder combines the two-bit ALU mode with the instruction's function field and produces the three-bit ALU operation code.

The inputs are the opcode and function field held in the instruction register, and the ALU zero flag. The outputs go straight to the datapath multiplexers and to the write enables. The current step code is also brought out so that the datapath and the bench can follow the sequence.

Top module: `mcc_control_fsm`

## Requirements
- R1: While `rst_n` is low, the step code is 0 (fetch) and the fetch controls of R2 are driven. Reset acts asynchronously and takes effect even in the middle of an instruction.
- R2: The fetch step (code 0) drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `pc_src`=0 (ALU result), `addr_sel`=0 (PC), `src_a`=0 (PC), `src_b`=01 (constant 4) and `alu_op`=00. All other controls are 0.
- R3: Fetch is always followed by the decode step (code 1). Decode drives `src_a`=0, `src_b`=11 (sign-extended immediate shifted left by 2) and `alu_op`=00, with every write enable at 0.
- R4: After decode, the next step depends on the opcode. Opcode 000100 (branch-equal) goes to code 8. Opcode 000000 (register-register) goes to code 6. Opcodes 100011 (load) and 101011 (store) go to code 2. Any other opcode returns to fetch with no write.
- R5: The address step (code 2) drives `src_a`=1 (register A), `src_b`=10 (sign-extended immediate) and `alu_op`=00. A store then goes to code 5 (`mem_wr`=1, `addr_sel`=1). A load goes to code 3 (`mem_rd`=1, `addr_sel`=1) and then to code 4 (`reg_wr`=1, `mem_to_reg`=1, `reg_dst`=0).
- R6: The execute step (code 6) drives `src_a`=1, `src_b`=00 (register B) and `alu_op`=10. It is followed by code 7, which drives `reg_wr`=1, `reg_dst`=1 (rd field) and `mem_to_reg`=0 (ALU output).
- R7: The branch step (code 8) drives `src_a`=1, `src_b`=00, `alu_op`=01 and `pc_src`=1 (saved target). In that step `pc_wr` equals `zero`.
- R8: The steps with codes 4, 5, 7 and 8 always return to fetch on the next clock.
- R9: `ir_wr` is 1 only in fetch. `mem_wr` is 1 only in code 5. `reg_wr` is 1 only in codes 4 and 7. `pc_wr` is 1 only in fetch, or in code 8 when `zero` is 1.
- R10: `alu_op` 00 gives `alu_fn` 010 (add) and `alu_op` 01 gives `alu_fn` 110 (subtract), whatever the function field holds.
- R11: With `alu_op` 10, the function field selects the operation: 100000 gives 010, 100010 gives 110, 100100 gives 000, 100101 gives 001 and 101010 gives 111. Any other function value gives 010.
- R12: Counted from fetch back to fetch, an instruction takes 3 cycles for a branch, 4 for register-register, 4 for a store, 5 for a load and 2 for an unknown opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Program counter write enable |
| ir_wr | output | 1 | Instruction register write enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| reg_wr | output | 1 | Register file write enable |
| addr_sel | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| src_a | output | 1 | ALU input A select: 0 PC, 1 register A |
| src_b | output | 2 | ALU input B select: 00 reg B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU mode: 00 add, 01 subtract, 10 function field |
| alu_fn | output | 3 | Decoded ALU operation code |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| reg_dst | output | 1 | Write register select: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data select: 0 ALU output, 1 memory data |
| step | output | 4 | Current step code |

## Verification
The hardest situations to reach are a reset that arrives partway through an instruction and a function field that must be ignored while it holds a meaningful code. The bench starts a register-register instruction, lets it reach the execute step, and then pulls reset low between clock edges to check that fetch returns at once. For the second situation, the function field is loaded with logical and set-less-than codes during branch, load and store sequences, so that a leak into the fixed add and subtract modes would show on `alu_fn`. The branch class is run with the zero flag at both values, which covers both outcomes of the conditional PC write.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int ALUFN_W = 3;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MEMRD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MEMWR  = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8
  } step_e;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [ALUFN_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALUFN_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALUFN_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALUFN_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALUFN_W-1:0] ALU_SLT = 3'b111;

  typedef struct packed {
    logic       pc_wr_u;
    logic       pc_wr_c;
    logic       ir_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       reg_wr;
    logic       addr_sel;
    logic       src_a;
    logic [1:0] src_b;
    logic [1:0] alu_op;
    logic       pc_src;
    logic       reg_dst;
    logic       mem_to_reg;
  } ctrl_t;
endpackage

// File: rtl/mcc_next_step.sv
module mcc_next_step
  import mcc_pkg::*;
#(
  parameter int OPW = OPC_W
) (
  input  step_e          cur,
  input  logic [OPW-1:0] opcode,
  output step_e          nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_BEQ)                               nxt = ST_BRANCH;
        else if (opcode == OPC_RTYPE)                        nxt = ST_EXEC;
        else if (opcode == OPC_LOAD || opcode == OPC_STORE)  nxt = ST_ADDR;
        else                                                 nxt = ST_FETCH;
      end
      ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_MEMWR : ST_MEMRD;
      ST_MEMRD:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_step_decode.sv
module mcc_step_decode
  import mcc_pkg::*;
(
  input  step_e cur,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd  = 1'b1;
        ctl.ir_wr   = 1'b1;
        ctl.pc_wr_u = 1'b1;
        ctl.src_b   = 2'b01;
        ctl.alu_op  = AOP_ADD;
      end
      ST_DECODE: begin
        ctl.src_b  = 2'b11;
        ctl.alu_op = AOP_ADD;
      end
      ST_ADDR: begin
        ctl.src_a  = 1'b1;
        ctl.src_b  = 2'b10;
        ctl.alu_op = AOP_ADD;
      end
      ST_MEMRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.reg_wr     = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      ST_MEMWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctl.src_a  = 1'b1;
        ctl.src_b  = 2'b00;
        ctl.alu_op = AOP_FUNCT;
      end
      ST_RWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = 1'b1;
      end
      ST_BRANCH: begin
        ctl.src_a   = 1'b1;
        ctl.src_b   = 2'b00;
        ctl.alu_op  = AOP_SUB;
        ctl.pc_wr_c = 1'b1;
        ctl.pc_src  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_alu_decode.sv
module mcc_alu_decode
  import mcc_pkg::*;
#(
  parameter int FW = FN_W,
  parameter int AW = ALUFN_W
) (
  input  logic [1:0]    alu_op,
  input  logic [FW-1:0] funct,
  output logic [AW-1:0] alu_fn
);
  logic [AW-1:0] fn_dec;

  always_comb begin
    unique case (funct)
      FN_ADD:  fn_dec = ALU_ADD;
      FN_SUB:  fn_dec = ALU_SUB;
      FN_AND:  fn_dec = ALU_AND;
      FN_OR:   fn_dec = ALU_OR;
      FN_SLT:  fn_dec = ALU_SLT;
      default: fn_dec = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (alu_op)
      AOP_SUB:   alu_fn = ALU_SUB;
      AOP_FUNCT: alu_fn = fn_dec;
      default:   alu_fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcc_control_fsm.sv
module mcc_control_fsm
  import mcc_pkg::*;
#(
  parameter int OPW = OPC_W,
  parameter int FW  = FN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   opcode,
  input  logic [FW-1:0]    funct,
  input  logic             zero,
  output logic             pc_wr,
  output logic             ir_wr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             reg_wr,
  output logic             addr_sel,
  output logic             src_a,
  output logic [1:0]       src_b,
  output logic [1:0]       alu_op,
  output logic [ALUFN_W-1:0] alu_fn,
  output logic             pc_src,
  output logic             reg_dst,
  output logic             mem_to_reg,
  output logic [3:0]       step
);
  step_e state_q, state_d;
  ctrl_t ctl;

  mcc_next_step #(.OPW(OPW)) u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_d)
  );

  mcc_step_decode u_ctl (
    .cur (state_q),
    .ctl (ctl)
  );

  mcc_alu_decode #(.FW(FW), .AW(ALUFN_W)) u_alu (
    .alu_op (ctl.alu_op),
    .funct  (funct),
    .alu_fn (alu_fn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign pc_wr      = ctl.pc_wr_u | (ctl.pc_wr_c & zero);
  assign ir_wr      = ctl.ir_wr;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign reg_wr     = ctl.reg_wr;
  assign addr_sel   = ctl.addr_sel;
  assign src_a      = ctl.src_a;
  assign src_b      = ctl.src_b;
  assign alu_op     = ctl.alu_op;
  assign pc_src     = ctl.pc_src;
  assign reg_dst    = ctl.reg_dst;
  assign mem_to_reg = ctl.mem_to_reg;
  assign step       = state_q;

  // R3: decode always follows fetch
  p_fetch_then_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  // R8: terminal steps return to fetch
  p_terminal_to_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_LDWB, ST_MEMWR, ST_RWB, ST_BRANCH}) |=> (state_q == ST_FETCH));

  // R9: a memory write only follows an address step
  p_memwr_after_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(state_q) == ST_ADDR));

  // R9: a register write only follows a memory read or an execute step
  p_regwr_after_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($past(state_q) inside {ST_MEMRD, ST_EXEC}));

  // R2: the instruction register is loaded for a single cycle per instruction
  p_irwr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> !ir_wr);

  // R7: the branch step writes the PC exactly when the operands are equal
  p_branch_pcwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRANCH) |-> (pc_wr == zero && alu_fn == ALU_SUB));
endmodule

// File: tb/mcc_control_fsm_tb.sv
module mcc_control_fsm_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       zero;
  logic       pc_wr, ir_wr, mem_rd, mem_wr, reg_wr, addr_sel, src_a;
  logic [1:0] src_b, alu_op;
  logic [2:0] alu_fn;
  logic       pc_src, reg_dst, mem_to_reg;
  logic [3:0] step;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  mcc_control_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .zero(zero),
    .pc_wr(pc_wr), .ir_wr(ir_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .reg_wr(reg_wr), .addr_sel(addr_sel), .src_a(src_a), .src_b(src_b),
    .alu_op(alu_op), .alu_fn(alu_fn), .pc_src(pc_src), .reg_dst(reg_dst),
    .mem_to_reg(mem_to_reg), .step(step)
  );

  // {pc_wr, ir_wr, mem_rd, mem_wr, reg_wr, addr_sel, src_a, src_b, alu_op, pc_src, reg_dst, mem_to_reg}
  function automatic logic [13:0] exp_ctrl(input logic [3:0] s, input logic z);
    case (s)
      4'd0: exp_ctrl = {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,1'b0,1'b0,1'b0};
      4'd1: exp_ctrl = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,1'b0,1'b0,1'b0};
      4'd2: exp_ctrl = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,1'b0,1'b0,1'b0};
      4'd3: exp_ctrl = {1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0};
      4'd4: exp_ctrl = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b1};
      4'd5: exp_ctrl = {1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0};
      4'd6: exp_ctrl = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,1'b0,1'b0,1'b0};
      4'd7: exp_ctrl = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b1,1'b0};
      4'd8: exp_ctrl = {z,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,1'b1,1'b0,1'b0};
      default: exp_ctrl = '0;
    endcase
  endfunction

  function automatic logic [13:0] act_ctrl();
    act_ctrl = {pc_wr, ir_wr, mem_rd, mem_wr, reg_wr, addr_sel, src_a,
                src_b, alu_op, pc_src, reg_dst, mem_to_reg};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one instruction from fetch; seq holds the expected step codes, 4 bits each.
  // ex_fn is the expected alu_fn in the execute step.
  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic z,
                           input logic [2:0] ex_fn, input logic [19:0] seq,
                           input int n, input string req);
    opcode = op; funct = fn; zero = z;
    for (int i = 0; i < n; i++) begin
      logic [3:0] es;
      logic [2:0] efn;
      es = seq[4*i +: 4];
      efn = (es == 4'd6) ? ex_fn : (es == 4'd8) ? 3'b110 : 3'b010;
      #1;
      chk(step == es, req, "step code (R3/R4/R5/R6)", step, es);
      chk(act_ctrl() == exp_ctrl(es, z), req, "controls R9", act_ctrl(), exp_ctrl(es, z));
      chk(alu_fn == efn, req, "alu_fn R10/R11", alu_fn, efn);
      @(negedge clk);
    end
    #1;
    chk(step == 4'd0, req, "back at fetch, cycle count R12 R8", step, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; opcode = 6'b000000; funct = 6'b0; zero = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(step == 4'd0, "R1", "reset step", step, 0);
    chk(act_ctrl() == exp_ctrl(4'd0, 1'b0), "R1", "reset controls", act_ctrl(), exp_ctrl(4'd0, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_rtype();
    run_instr(6'b000000, 6'b100000, 1'b0, 3'b010, {8'h0, 4'd7, 4'd6, 4'd1, 4'd0}, 4, "R6 add");
    run_instr(6'b000000, 6'b100010, 1'b0, 3'b110, {8'h0, 4'd7, 4'd6, 4'd1, 4'd0}, 4, "R11 sub");
    run_instr(6'b000000, 6'b100100, 1'b1, 3'b000, {8'h0, 4'd7, 4'd6, 4'd1, 4'd0}, 4, "R11 and");
    run_instr(6'b000000, 6'b100101, 1'b0, 3'b001, {8'h0, 4'd7, 4'd6, 4'd1, 4'd0}, 4, "R11 or");
    run_instr(6'b000000, 6'b101010, 1'b0, 3'b111, {8'h0, 4'd7, 4'd6, 4'd1, 4'd0}, 4, "R11 slt");
    run_instr(6'b000000, 6'b111111, 1'b0, 3'b010, {8'h0, 4'd7, 4'd6, 4'd1, 4'd0}, 4, "R11 unknown funct");
  endtask

  task automatic t_load();
    run_instr(6'b100011, 6'b101010, 1'b0, 3'b010, {4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 5, "R5 load R12");
  endtask

  task automatic t_store();
    run_instr(6'b101011, 6'b100100, 1'b1, 3'b010, {8'h0, 4'd5, 4'd2, 4'd1, 4'd0}, 4, "R5 store R12");
  endtask

  task automatic t_branch();
    run_instr(6'b000100, 6'b100100, 1'b1, 3'b010, {12'h0, 4'd8, 4'd1, 4'd0}, 3, "R7 taken R10");
    run_instr(6'b000100, 6'b101010, 1'b0, 3'b010, {12'h0, 4'd8, 4'd1, 4'd0}, 3, "R7 not taken R10");
  endtask

  task automatic t_unknown();
    run_instr(6'b001000, 6'b100000, 1'b0, 3'b010, {16'h0, 4'd1, 4'd0}, 2, "R4 unknown opcode");
  endtask

  task automatic t_mid_reset();
    opcode = 6'b000000; funct = 6'b100010; zero = 1'b0;
    @(negedge clk); @(negedge clk);
    #1;
    chk(step == 4'd6, "R1", "reached execute before reset", step, 6);
    rst_n = 1'b0;
    #1;
    chk(step == 4'd0, "R1", "async reset mid-instruction", step, 0);
    chk(act_ctrl() == exp_ctrl(4'd0, 1'b0), "R1", "controls after mid reset", act_ctrl(), exp_ctrl(4'd0, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_rtype();
    t_load();
    t_store();
    t_branch();
    t_unknown();
    t_mid_reset();
    t_load();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule